// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether a frame arriving on an Ethernet receive path is kept or thrown away. The first six data bytes of each frame form its destination address, and they reach the filter as a byte stream after a frame-start strobe. When the frame ends, a strobe carries the total byte count. One clock later the filter emits a single accept/discard verdict that the buffer logic downstream acts on.

Four configuration bits control the verdict, together with a minimum frame length, a programmed station address and a 64-bit hash table. The bits are: keep-short-frames, hash mode, promiscuous and broadcast-reject. An external reject input can veto the frame at any time during reception. The rules apply in a fixed order:

1. External reject.
2. Incomplete address or short frame.
3. Promiscuous.
4. Broadcast.
5. Group.
6. Individual match, either exact or hashed.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: During reset and in the first cycle after it, `dec_valid` and `dec_accept` are both 0.
- R2: `dec_valid` is 1 in exactly the cycle after a cycle with `frm_end` high, and 0 in every other cycle. `dec_accept` is 0 whenever `dec_valid` is 0.
- R3: If `cfg_keep_short` is 0 and `frm_len` < `cfg_min_len`, the frame is discarded. If `cfg_keep_short` is 1, the length has no effect. A frame with `frm_len` equal to `cfg_min_len` is not short.
- R4: If `cfg_hash_mode` is 0, an individual address (first byte bit 0 clear) is accepted only when it equals `station_addr`. The first byte received is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`.
- R5: If `cfg_hash_mode` is 1, an individual address is accepted only when `hash_table[idx]` is 1. To form `idx`, run a reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, no final inversion) over the six bytes in arrival order, with each byte taken least significant bit first. `idx` is register bits [31:26] as an unsigned number.
- R6: If `cfg_promisc` is 1, a frame with a complete address is accepted whatever its address, unless R9, R10 or R3 discard it.
- R7: The broadcast address (all six bytes 0xFF) is accepted when `cfg_bcast_reject` is 0. When `cfg_bcast_reject` is 1 it is discarded, unless `cfg_promisc` is 1.
- R8: A group address (first byte bit 0 set, not broadcast) is discarded unless `cfg_promisc` is 1.
- R9: If `ext_reject` is high in any cycle from `rx_sof` through the `frm_end` cycle inclusive, the frame is discarded. This rule overrides all others.
- R10: A frame that ends with fewer than six bytes received is discarded.
- R11: `rx_sof` clears the captured address, byte count and reject history, so each frame is judged only on its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_keep_short | input | 1 | Keep frames shorter than the minimum |
| cfg_hash_mode | input | 1 | Use the hash table for individual addresses |
| cfg_promisc | input | 1 | Accept any address |
| cfg_bcast_reject | input | 1 | Discard broadcast unless promiscuous |
| cfg_min_len | input | 16 | Minimum frame length in bytes |
| station_addr | input | 48 | Programmed station address, first wire byte in [47:40] |
| hash_table | input | 64 | Individual-address hash table |
| rx_sof | input | 1 | Frame-start strobe |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| ext_reject | input | 1 | External veto for the current frame |
| frm_end | input | 1 | Frame-end strobe |
| frm_len | input | 16 | Total frame byte count, valid with `frm_end` |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Verdict: 1 keep, 0 discard |

## Verification
The assertions assume three things about the inputs:
- `rx_sof` comes in a cycle of its own, before the frame's bytes.
- `frm_end` comes at least one cycle after the last byte, never in two consecutive cycles, and is not followed by more bytes before the next `rx_sof`.
- The configuration inputs stay constant for the whole frame.

The bench keeps to these assumptions by driving each frame through one task. That task spaces the frame-start, byte and frame-end phases on separate falling edges, and the bench changes configuration only between frames. Within these limits the bench sweeps all sixteen combinations of the configuration bits. It pairs each with six address classes, three hash tables, short and full lengths, and a reject or no reject. Directed frames cover the length boundary, truncated addresses and a reject raised on the frame-end cycle.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;

    localparam int          MAC_BYTES  = 6;
    localparam int          MAC_W      = 8 * MAC_BYTES;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        KIND_INDIV = 2'd0,
        KIND_GROUP = 2'd1,
        KIND_BCAST = 2'd2
    } addr_kind_e;

    typedef struct packed {
        logic keep_short;
        logic hash_mode;
        logic promisc;
        logic bcast_reject;
    } filt_cfg_t;

    // Advance a reflected CRC register by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [7:0]       d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_R;
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_filt_capture.sv
module eth_filt_capture
    import eth_filt_pkg::*;
#(
    parameter int N_BYTES   = MAC_BYTES,
    parameter int HASH_BITS = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sof,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_in,
    output logic [8*N_BYTES-1:0]   addr,
    output logic                   addr_done,
    output logic [HASH_BITS-1:0]   hash_idx
);
    localparam int CNT_W = $clog2(N_BYTES + 1);

    logic [CNT_W-1:0] cnt;
    logic [CRC_W-1:0] crc;

    always_ff @(posedge clk) begin
        if (rst || sof) begin
            cnt       <= '0;
            addr      <= '0;
            crc       <= CRC_PRESET;
            addr_done <= 1'b0;
        end else if (byte_valid && !addr_done) begin
            addr <= {addr[8*N_BYTES-9:0], byte_in};
            crc  <= crc_step(crc, byte_in);
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(N_BYTES - 1)) addr_done <= 1'b1;
        end
    end

    assign hash_idx = crc[CRC_W-1 -: HASH_BITS];

endmodule

// File: rtl/eth_filt_classify.sv
module eth_filt_classify
    import eth_filt_pkg::*;
#(
    parameter int N_BYTES   = MAC_BYTES,
    parameter int HASH_BITS = 6
) (
    input  logic [8*N_BYTES-1:0]      addr,
    input  logic [8*N_BYTES-1:0]      station,
    input  logic [(1<<HASH_BITS)-1:0] table_bits,
    input  logic [HASH_BITS-1:0]      hash_idx,
    input  logic                      hash_mode,
    output addr_kind_e                kind,
    output logic                      indiv_hit
);
    localparam int AW = 8 * N_BYTES;

    logic all_ones;
    logic grp_bit;
    logic exact_hit;
    logic hashed_hit;

    assign all_ones   = &addr;
    assign grp_bit    = addr[AW-8];
    assign exact_hit  = (addr == station);
    assign hashed_hit = table_bits[hash_idx];

    always_comb begin
        if (all_ones)     kind = KIND_BCAST;
        else if (grp_bit) kind = KIND_GROUP;
        else              kind = KIND_INDIV;
    end

    assign indiv_hit = hash_mode ? hashed_hit : exact_hit;

endmodule

// File: rtl/eth_filt_decide.sv
module eth_filt_decide
    import eth_filt_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             ext_reject,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] min_len,
    input  filt_cfg_t        cfg,
    input  logic             addr_done,
    input  addr_kind_e       kind,
    input  logic             indiv_hit,
    output logic             out_valid,
    output logic             out_accept
);
    logic rej_seen;
    logic vetoed;
    logic too_short;
    logic verdict;

    always_ff @(posedge clk) begin
        if (rst)      rej_seen <= 1'b0;
        else if (sof) rej_seen <= ext_reject;
        else          rej_seen <= rej_seen | ext_reject;
    end

    assign vetoed    = rej_seen | ext_reject;
    assign too_short = !cfg.keep_short && (frame_len < min_len);

    always_comb begin
        if (vetoed || too_short || !addr_done) verdict = 1'b0;
        else if (cfg.promisc)                  verdict = 1'b1;
        else begin
            unique case (kind)
                KIND_BCAST: verdict = !cfg.bcast_reject;
                KIND_GROUP: verdict = 1'b0;
                default:    verdict = indiv_hit;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
        end else begin
            out_valid  <= frame_end;
            out_accept <= frame_end & verdict;
        end
    end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import eth_filt_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int HASH_BITS = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_keep_short,
    input  logic                      cfg_hash_mode,
    input  logic                      cfg_promisc,
    input  logic                      cfg_bcast_reject,
    input  logic [LEN_W-1:0]          cfg_min_len,
    input  logic [MAC_W-1:0]          station_addr,
    input  logic [(1<<HASH_BITS)-1:0] hash_table,
    input  logic                      rx_sof,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_byte,
    input  logic                      ext_reject,
    input  logic                      frm_end,
    input  logic [LEN_W-1:0]          frm_len,
    output logic                      dec_valid,
    output logic                      dec_accept
);
    filt_cfg_t              cfg;
    logic [MAC_W-1:0]       cap_addr;
    logic                   cap_done;
    logic [HASH_BITS-1:0]   cap_idx;
    addr_kind_e             cls_kind;
    logic                   cls_hit;

    assign cfg = '{keep_short:   cfg_keep_short,
                   hash_mode:    cfg_hash_mode,
                   promisc:      cfg_promisc,
                   bcast_reject: cfg_bcast_reject};

    eth_filt_capture #(.N_BYTES(MAC_BYTES), .HASH_BITS(HASH_BITS)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .sof        (rx_sof),
        .byte_valid (rx_valid),
        .byte_in    (rx_byte),
        .addr       (cap_addr),
        .addr_done  (cap_done),
        .hash_idx   (cap_idx)
    );

    eth_filt_classify #(.N_BYTES(MAC_BYTES), .HASH_BITS(HASH_BITS)) u_cls (
        .addr       (cap_addr),
        .station    (station_addr),
        .table_bits (hash_table),
        .hash_idx   (cap_idx),
        .hash_mode  (cfg.hash_mode),
        .kind       (cls_kind),
        .indiv_hit  (cls_hit)
    );

    eth_filt_decide #(.LEN_W(LEN_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .sof        (rx_sof),
        .ext_reject (ext_reject),
        .frame_end  (frm_end),
        .frame_len  (frm_len),
        .min_len    (cfg_min_len),
        .cfg        (cfg),
        .addr_done  (cap_done),
        .kind       (cls_kind),
        .indiv_hit  (cls_hit),
        .out_valid  (dec_valid),
        .out_accept (dec_accept)
    );

endmodule

// File: rtl/eth_filt_chk.sv
module eth_filt_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_keep_short,
    input logic        cfg_promisc,
    input logic        cfg_bcast_reject,
    input logic [15:0] cfg_min_len,
    input logic        rx_sof,
    input logic        rx_valid,
    input logic [7:0]  rx_byte,
    input logic        ext_reject,
    input logic        frm_end,
    input logic [15:0] frm_len,
    input logic        dec_valid,
    input logic        dec_accept
);
    logic [2:0] seen;
    logic       all_ff;
    logic       rej_any;

    always_ff @(posedge clk) begin
        if (rst || rx_sof) begin
            seen    <= '0;
            all_ff  <= 1'b1;
            rej_any <= rst ? 1'b0 : ext_reject;
        end else begin
            rej_any <= rej_any | ext_reject;
            if (rx_valid && seen < 3'd6) begin
                seen   <= seen + 3'd1;
                all_ff <= all_ff & (rx_byte == 8'hFF);
            end
        end
    end

    // R2
    pulse_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid == $past(frm_end));

    // R2
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> dec_valid);

    // R3
    short_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_end && !cfg_keep_short && frm_len < cfg_min_len) |=> !dec_accept);

    // R9
    veto_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_end && (ext_reject || rej_any)) |=> !dec_accept);

    // R10
    truncated_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_end && seen < 3'd6) |=> !dec_accept);

    // R7
    bcast_block_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_end && seen == 3'd6 && all_ff && cfg_bcast_reject && !cfg_promisc)
        |=> !dec_accept);

endmodule

bind eth_rx_addr_filter eth_filt_chk u_chk (.*);

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;

    localparam logic [31:0] POLY = 32'hEDB8_8320;
    localparam logic [47:0] STN  = 48'h02_1A_3C_4D_5E_6F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_keep_short = 0, cfg_hash_mode = 0, cfg_promisc = 0, cfg_bcast_reject = 0;
    logic [15:0] cfg_min_len = 16'd60;
    logic [47:0] station_addr = STN;
    logic [63:0] hash_table = '0;
    logic        rx_sof = 0, rx_valid = 0, ext_reject = 0, frm_end = 0;
    logic [7:0]  rx_byte = '0;
    logic [15:0] frm_len = '0;
    logic        dec_valid, dec_accept;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    eth_rx_addr_filter i_eth_rx_addr_filter (.*);

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 48; b++) begin
            logic bit_in = a[47 - 8*(b/8) - 7 + (b%8)];
            logic mix    = c[0] ^ bit_in;
            c = {1'b0, c[31:1]} ^ (mix ? POLY : 32'h0);
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a, input int nb,
                                        input logic [15:0] len, input bit rej);
        if (rej || nb < 6) return 0;
        if (!cfg_keep_short && len < cfg_min_len) return 0;
        if (cfg_promisc) return 1;
        if (a == 48'hFFFF_FFFF_FFFF) return !cfg_bcast_reject;
        if (a[40]) return 0;
        if (cfg_hash_mode) return hash_table[ref_idx(a)];
        return a == STN;
    endfunction

    function automatic string ref_tag(input logic [47:0] a, input int nb,
                                      input logic [15:0] len, input bit rej);
        if (rej) return "R9";
        if (nb < 6) return "R10";
        if (len < cfg_min_len) return "R3";
        if (cfg_promisc) return "R6";
        if (a == 48'hFFFF_FFFF_FFFF) return "R7";
        if (a[40]) return "R8";
        if (cfg_hash_mode) return "R5";
        return "R4";
    endfunction

    // rej_at: -1 none, 0..nb-1 during that byte, 99 on the frame-end cycle
    task automatic frame(input logic [47:0] a, input int nb, input logic [15:0] len,
                         input int rej_at);
        logic exp;
        string tag;
        exp = ref_accept(a, nb, len, rej_at >= 0);
        tag = ref_tag(a, nb, len, rej_at >= 0);
        @(negedge clk); rx_sof = 1;
        @(negedge clk); rx_sof = 0;
        for (int i = 0; i < nb; i++) begin
            rx_valid = 1; rx_byte = a[47-8*i -: 8]; ext_reject = (rej_at == i);
            @(negedge clk);
        end
        rx_valid = 0; ext_reject = 0;
        @(negedge clk);
        frm_end = 1; frm_len = len; ext_reject = (rej_at == 99);
        @(negedge clk);
        frm_end = 0; ext_reject = 0;
        check("R2", dec_valid, 1'b1);
        check(tag, dec_accept, exp);
        @(negedge clk);
        check("R2", dec_valid, 1'b0);
        check("R2", dec_accept, 1'b0);
    endtask

    initial begin
        logic [47:0] addrs [6];
        logic [63:0] tables [3];
        addrs[0] = STN;
        addrs[1] = STN ^ 48'h1;
        addrs[2] = 48'hFFFF_FFFF_FFFF;
        addrs[3] = 48'h01_00_5E_00_00_FB;
        addrs[4] = 48'h00_11_22_33_44_55;
        addrs[5] = 48'h0A_BB_CC_DD_EE_F0;
        tables[0] = '1;
        tables[1] = '0;
        tables[2] = 64'hA5C3_0F96_3C5A_E187;

        repeat (3) @(negedge clk);
        check("R1", dec_valid, 1'b0);
        check("R1", dec_accept, 1'b0);
        rst = 0;
        @(negedge clk);
        check("R1", dec_valid, 1'b0);
        check("R1", dec_accept, 1'b0);

        for (int c = 0; c < 16; c++) begin
            {cfg_keep_short, cfg_hash_mode, cfg_promisc, cfg_bcast_reject} = 4'(c);
            for (int t = 0; t < 3; t++) begin
                hash_table = tables[t];
                for (int a = 0; a < 6; a++)
                    for (int l = 0; l < 2; l++)
                        for (int r = 0; r < 2; r++)
                            frame(addrs[a], 6, l ? 16'd64 : 16'd40, r ? 3 : -1);
            end
        end

        // R3 boundary: length equal to minimum is not short, one less is
        {cfg_keep_short, cfg_hash_mode, cfg_promisc, cfg_bcast_reject} = 4'b0000;
        frame(STN, 6, 16'd60, -1);
        frame(STN, 6, 16'd59, -1);
        cfg_keep_short = 1;
        frame(STN, 6, 16'd59, -1);
        // R9: reject on the frame-end cycle and on the first byte
        cfg_promisc = 1;
        frame(STN, 6, 16'd64, 99);
        frame(STN, 6, 16'd64, 0);
        // R10: truncated address, even promiscuous
        frame(STN, 3, 16'd64, -1);
        frame(48'hFFFF_FFFF_FFFF, 5, 16'd64, -1);
        // R11: a vetoed frame leaves no trace on the next one
        cfg_promisc = 0;
        frame(STN, 6, 16'd64, 2);
        frame(STN, 6, 16'd64, -1);
        check("R11", 1'b1, ref_accept(STN, 6, 16'd64, 0));
        // R4: a single wrong byte in the middle fails the exact compare
        frame(STN ^ 48'h0000_0100_0000, 6, 16'd64, -1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule